// File: doc/BRIEF.md
# Serially Loaded Address Breakpoint Unit

This block watches the processor bus and asks a single-step controller to halt when the bus presents a chosen address. An external controller shifts in the target address one bit at a time over a serial data line with its own shift clock. A latch pulse then copies the shifted word into the compare register, so the value being compared never changes part way through a load. Once the value is loaded, the controller lowers an active-low arm input to enable detection.

The compare value has three byte fields: bank, address high and address low. Each field is checked for equality on its own, as an XOR against the inverted compare byte followed by an AND of all bits. The three results are combined and sampled only on a bus cycle marked valid. Glitches in the compare logic while the address is settling therefore cannot raise a halt. A narrow mode parameter drops the bank field, for processors that have no bank byte. The halt request is held until the arm input goes high or reset is applied.

Top module: `bp_watch_top`

## Requirements
- R1: After reset, `haltReq` is 0 and the compare register holds zero.
- R2: Each rising edge of `serClk` shifts `serData` into the 24-bit shift register, MSB first. After 24 edges, the first bit sent is bit 23 (bank bit 7) and the last bit sent is bit 0.
- R3: A rising edge of `serLatch` copies the shift register into the compare register. Shifting alone does not change which address matches.
- R4: With `armN` low, a valid cycle whose bank (bits 23:16), high byte (15:8) and low byte (7:0) all equal the compare value sets `haltReq` on the next clock.
- R5: A bus cycle with `cycleValid` low never sets `haltReq`, even when the address matches.
- R6: While `armN` is high, `haltReq` is 0 one clock later and no match can set it.
- R7: Once set, `haltReq` stays at 1 while `armN` stays low, whatever the bus then shows.
- R8: A difference in any single field (bank, high byte or low byte) prevents `haltReq` from being set when the bank field is compared.
- R9: With `WIDE_MODE`=0, the bank field is ignored: a valid armed cycle matching only the 16-bit address sets `haltReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serData | input | 1 | Serial compare data, MSB first |
| serClk | input | 1 | Serial shift clock, sampled; rising edge shifts |
| serLatch | input | 1 | Rising edge loads the compare register |
| armN | input | 1 | Active-low detection enable; high clears the request |
| bankIn | input | BANK_W | Latched bank byte of the current bus cycle |
| addrIn | input | ADDR_W | 16-bit bus address |
| cycleValid | input | 1 | Marks the clock on which bank and address are settled |
| haltReq | output | 1 | Sticky halt request to the single-step controller |

## Verification
The bench builds two instances on shared stimulus. One uses the default wide mode, where a single-field difference in the bank, high or low byte must suppress the request. The other uses `WIDE_MODE`=0, which brings bank-only mismatches within reach: there the same stimulus must still raise the request. Reloading a second, asymmetric word checks the MSB-first bit order. It also shows that a shifted value has no effect until it is latched.

// File: rtl/bp_watch_pkg.sv
package bp_watch_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shift;
    logic load;
  } bpwStrobe_t;
endpackage

// File: rtl/bp_watch_datapath.sv
module bp_watch_datapath
  import bp_watch_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BANK_W    = 8,
  parameter int FIELD_W   = 8,
  parameter bit WIDE_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpwStrobe_t        stb,
  input  logic              serData,
  input  logic [BANK_W-1:0] bankIn,
  input  logic [ADDR_W-1:0] addrIn,
  output logic              matchAll
);
  localparam int TOTAL_W     = ADDR_W + BANK_W;
  localparam int NUM_FIELDS  = TOTAL_W / FIELD_W;
  localparam int ADDR_FIELDS = ADDR_W / FIELD_W;

  logic [TOTAL_W-1:0]    shiftReg;
  logic [TOTAL_W-1:0]    cmpReg;
  logic [TOTAL_W-1:0]    busWord;
  logic [NUM_FIELDS-1:0] fieldEq;

  assign busWord = {bankIn, addrIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      cmpReg   <= '0;
    end else begin
      if (stb.shift) shiftReg <= {shiftReg[TOTAL_W-2:0], serData};
      if (stb.load)  cmpReg   <= shiftReg;
    end
  end

  // Per-field equality: XOR against inverted compare byte, then AND-reduce
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    if (!WIDE_MODE && i >= ADDR_FIELDS) begin : g_skip
      assign fieldEq[i] = 1'b1;
    end else begin : g_cmp
      assign fieldEq[i] = &(busWord[i*FIELD_W +: FIELD_W] ^ ~cmpReg[i*FIELD_W +: FIELD_W]);
    end
  end

  assign matchAll = &fieldEq;

  // R3: compare value only moves on a load strobe
  p_cmp_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(cmpReg));
  // R2: newest bit lands in position 0
  p_shift_lsb_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> shiftReg[0] == $past(serData));
endmodule

// File: rtl/bp_watch_control.sv
module bp_watch_control
  import bp_watch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serLatch,
  input  logic       armN,
  input  logic       cycleValid,
  input  logic       matchAll,
  output bpwStrobe_t stb,
  output logic       haltReq
);
  logic serClkQ;
  logic serLatchQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serClkQ   <= 1'b0;
      serLatchQ <= 1'b0;
      haltReq   <= 1'b0;
    end else begin
      serClkQ   <= serClk;
      serLatchQ <= serLatch;
      if (armN)
        haltReq <= 1'b0;
      else if (cycleValid && matchAll)
        haltReq <= 1'b1;
    end
  end

  always_comb begin
    stb.shift = serClk & ~serClkQ;
    stb.load  = serLatch & ~serLatchQ;
  end

  // R4: a request only starts from an armed, valid, matching cycle
  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltReq) |-> $past(!armN && cycleValid && matchAll));
  // R6: disarm clears the request
  p_disarm_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    armN |=> !haltReq);
  // R7: request holds while armed
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    haltReq && !armN |=> haltReq);
  // R5: no valid cycle, no new request
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !haltReq && !cycleValid |=> !haltReq);
endmodule

// File: rtl/bp_watch_top.sv
module bp_watch_top
  import bp_watch_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BANK_W    = 8,
  parameter int FIELD_W   = 8,
  parameter bit WIDE_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serData,
  input  logic              serClk,
  input  logic              serLatch,
  input  logic              armN,
  input  logic [BANK_W-1:0] bankIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              cycleValid,
  output logic              haltReq
);
  bpwStrobe_t stb;
  logic       matchAll;

  bp_watch_control u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serLatch(serLatch),
    .armN(armN), .cycleValid(cycleValid), .matchAll(matchAll),
    .stb(stb), .haltReq(haltReq)
  );

  bp_watch_datapath #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .FIELD_W(FIELD_W), .WIDE_MODE(WIDE_MODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .serData(serData),
    .bankIn(bankIn), .addrIn(addrIn), .matchAll(matchAll)
  );
endmodule

// File: tb/bp_watch_top_test.sv
module bp_watch_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serData = 1'b0;
  logic        serClk = 1'b0;
  logic        serLatch = 1'b0;
  logic        armN = 1'b1;
  logic [7:0]  bankIn = 8'h00;
  logic [15:0] addrIn = 16'h0000;
  logic        cycleValid = 1'b0;
  logic        haltWide;
  logic        haltNarrow;

  int    nTests = 0;
  int    nFail = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  bp_watch_top uut (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
    .serLatch(serLatch), .armN(armN), .bankIn(bankIn), .addrIn(addrIn),
    .cycleValid(cycleValid), .haltReq(haltWide)
  );

  bp_watch_top #(.WIDE_MODE(1'b0)) uutNarrow (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
    .serLatch(serLatch), .armN(armN), .bankIn(bankIn), .addrIn(addrIn),
    .cycleValid(cycleValid), .haltReq(haltNarrow)
  );

  // Behavioural reference
  logic [23:0] mShift = '0, mCmp = '0;
  logic        mClkPrev = 0, mLatPrev = 0, mHaltW = 0, mHaltN = 0;

  always @(posedge clk) begin
    logic [23:0] oldShift;
    logic        eqW, eqN;
    if (!rstN) begin
      mShift = '0; mCmp = '0; mClkPrev = 0; mLatPrev = 0; mHaltW = 0; mHaltN = 0;
    end else begin
      oldShift = mShift;
      eqN = (addrIn == mCmp[15:0]);
      eqW = eqN && (bankIn == mCmp[23:16]);
      if (serClk && !mClkPrev) mShift = {mShift[22:0], serData};
      if (serLatch && !mLatPrev) mCmp = oldShift;
      mClkPrev = serClk;
      mLatPrev = serLatch;
      if (armN) begin mHaltW = 0; mHaltN = 0; end
      else if (cycleValid) begin
        if (eqW) mHaltW = 1;
        if (eqN) mHaltN = 1;
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      check({curReq, " model wide"}, haltWide, mHaltW);
      check({curReq, " model narrow"}, haltNarrow, mHaltN);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic sendWord(logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      serData = w[i]; serClk = 1'b1; tick();
      serClk = 1'b0; tick();
    end
  endtask

  task automatic doLatch();
    serLatch = 1'b1; tick();
    serLatch = 1'b0; tick();
  endtask

  task automatic bus(logic [7:0] b, logic [15:0] a, logic v);
    bankIn = b; addrIn = a; cycleValid = v; tick();
    cycleValid = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nFail++; nTests++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nTests, nFail);
        $finish;
      end
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1; tick();
    curReq = "R1";
    check("R1 reset wide", haltWide, 1'b0);
    check("R1 reset narrow", haltNarrow, 1'b0);

    // R3: shifted but unlatched value has no effect
    curReq = "R3";
    sendWord(24'h123456);
    armN = 1'b0; tick();
    bus(8'h12, 16'h3456, 1'b1);
    check("R3 no match before latch", haltWide, 1'b0);
    doLatch();

    // R4 / R9 match
    curReq = "R4";
    bus(8'h12, 16'h3456, 1'b1);
    check("R4 full match sets halt", haltWide, 1'b1);
    check("R9 narrow also halts", haltNarrow, 1'b1);

    // R7 sticky
    curReq = "R7";
    bus(8'h00, 16'hFFFF, 1'b1);
    bus(8'h55, 16'h0101, 1'b0);
    check("R7 halt held while armed", haltWide, 1'b1);

    // R6 clear
    curReq = "R6";
    armN = 1'b1; tick();
    check("R6 disarm clears", haltWide, 1'b0);
    bus(8'h12, 16'h3456, 1'b1);
    check("R6 disarmed match ignored", haltWide, 1'b0);
    armN = 1'b0; tick();

    // R5 invalid cycle
    curReq = "R5";
    bus(8'h12, 16'h3456, 1'b0);
    tick();
    check("R5 invalid cycle no halt", haltWide, 1'b0);

    // R8 / R9 single-field mismatches
    curReq = "R8";
    bus(8'h13, 16'h3456, 1'b1);
    check("R8 bank mismatch wide", haltWide, 1'b0);
    check("R9 bank ignored narrow", haltNarrow, 1'b1);
    armN = 1'b1; tick(); armN = 1'b0; tick();
    bus(8'h12, 16'h3556, 1'b1);
    check("R8 high byte mismatch", haltWide, 1'b0);
    check("R8 high byte mismatch narrow", haltNarrow, 1'b0);
    bus(8'h12, 16'h3457, 1'b1);
    check("R8 low byte mismatch", haltWide, 1'b0);

    // R2 MSB-first order with an asymmetric word
    curReq = "R2";
    sendWord(24'hABCDEF);
    bus(8'hAB, 16'hCDEF, 1'b1);
    check("R2 old value still active", haltWide, 1'b0);
    doLatch();
    bus(8'hF7, 16'hB3D5, 1'b1);
    check("R2 bit-reversed does not match", haltWide, 1'b0);
    bus(8'hAB, 16'hCDEF, 1'b1);
    check("R2 MSB-first word matches", haltWide, 1'b1);
    armN = 1'b1; tick(); tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule